// File: doc/BRIEF.md
# Deferred Coefficient RAM Update Engine

This block rewrites a coefficient RAM while a DSP program keeps reading it. A host sends serial byte sequences framed by a request line. A staging command carries up to a fixed number of 16-bit words, and the block holds them in a staging buffer. A later write command carries a start address. From then on the engine watches the execution address at which the running program reads coefficients. Each staged word goes into the RAM only in the cycle in which the execution address equals that word's target. Targets are served strictly one after another in ascending order. The program therefore never sees a later coefficient updated before an earlier one.

A ready output tells the host when it may send the next command. Ready drops for one cycle when a staging sequence closes. It drops again from the write command until every staged word has been committed and a minimum busy interval has passed. That interval is shorter when more words were staged. A write command with nothing staged, or with a malformed address, raises an error flag and writes nothing. The RAM read port returns data one cycle after the execution address is applied. When a commit and a read hit the same word in the same cycle, the read returns the newly written value.

Top module: `coef_defer_wr`

## Requirements
- R1: While reset is high and in the first cycle after it, `host_rdy` is 1 and `cmd_err` is 0.
- R2: Sending command byte 0xA8 starts a staging sequence. Each following pair of bytes forms one word, high byte first. At most DEPTH (16) words are kept, and further words in the same sequence are ignored. The sequence closes when `host_req` drops.
- R3: Command byte 0xA4 is followed by an address-high byte, whose bits 1:0 give address bits 9:8, and then an address-low byte that gives bits 7:0. Staged word i targets start address + i, modulo the RAM depth.
- R4: A staged word is written only in a cycle in which `exec_addr` equals its target address.
- R5: Commits happen in strict ascending order. While target k is still pending, a read at target k+1 does not write it, and that word is written on a later visit after k has been committed.
- R6: A write command with no closed staging sequence since the last write command, or with a nonzero bit in bits 7:2 of the address-high byte, sets `cmd_err` and writes nothing. `cmd_err` clears when the next command byte is accepted.
- R7: Closing a staging sequence that holds at least one word drives `host_rdy` low for exactly one cycle.
- R8: After an accepted write command of n words, `host_rdy` stays low until all n words have been committed and at least (16-n)*2 clock cycles have passed.
- R9: An incomplete byte or an incomplete word pair left when `host_req` drops is discarded.
- R10: `coef_rd` shows the RAM word at the `exec_addr` of the previous cycle. If that word was committed in that cycle, `coef_rd` shows the new value.
- R11: Bytes received while a commit is in progress, including a complete staging sequence, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request line, high while a byte sequence is being sent |
| host_sclk | input | 1 | Serial bit clock; a bit is taken on each rising edge |
| host_sdi | input | 1 | Serial data, MSB first |
| exec_addr | input | AW | Coefficient read address of the running program |
| coef_rd | output | DW | Coefficient read data, one cycle after exec_addr |
| host_rdy | output | 1 | High when the engine accepts a new command |
| cmd_err | output | 1 | Malformed or unprepared write command |

## Verification
The bench uses the default sizes: 10-bit addresses, 16-bit words and a 16-word staging buffer. This makes both ends of the busy-time formula reachable. A full 16-word stage gives no extra minimum wait. A single word gives a 30-cycle wait that outlasts its own commit. The address pattern revisits targets out of order, so both the blocked early visits and the later commits in order are observed. The same stage is also overrun with a seventeenth word.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam logic [7:0] CMD_STAGE = 8'hA8;
  localparam logic [7:0] CMD_WRITE = 8'hA4;

  typedef enum logic [2:0] {
    DS_CMD,
    DS_WHI,
    DS_WLO,
    DS_AHI,
    DS_ALO,
    DS_SKIP
  } dec_st_t;
endpackage

// File: rtl/coef_ser_rx.sv
module coef_ser_rx #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       sclk_i,
  input  logic       sdi_i,
  output logic       byte_vld,
  output logic [7:0] byte_q,
  output logic       seq_end
);
  logic [SYNC-1:0] req_s, sclk_s, sdi_s;
  logic            req_d, sclk_d;
  logic [2:0]      bit_cnt;
  logic            req_now, rise;

  assign req_now = req_s[SYNC-1];
  assign rise    = sclk_s[SYNC-1] & ~sclk_d;
  assign seq_end = req_d & ~req_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_s    <= '0;
      sclk_s   <= '0;
      sdi_s    <= '0;
      req_d    <= 1'b0;
      sclk_d   <= 1'b0;
      bit_cnt  <= '0;
      byte_q   <= '0;
      byte_vld <= 1'b0;
    end else begin
      req_s    <= {req_s[SYNC-2:0], req_i};
      sclk_s   <= {sclk_s[SYNC-2:0], sclk_i};
      sdi_s    <= {sdi_s[SYNC-2:0], sdi_i};
      req_d    <= req_now;
      sclk_d   <= sclk_s[SYNC-1];
      byte_vld <= 1'b0;
      if (!req_now) begin
        bit_cnt <= '0;
      end else if (rise) begin
        byte_q  <= {byte_q[6:0], sdi_s[SYNC-1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) byte_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/coef_cmd_dec.sv
module coef_cmd_dec
  import coef_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 10,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_vld,
  input  logic [7:0]    byte_i,
  input  logic          seq_end,
  input  logic          busy,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_word,
  output logic          start,
  output logic [AW-1:0] start_addr,
  output logic [CW-1:0] n_words,
  output logic          stage_close,
  output logic          err
);
  dec_st_t       st;
  logic [7:0]    hi_q;
  logic          staged;
  logic [DW-1:0] stage_mem [DEPTH];
  logic          word_we;
  logic [15:0]   wide_addr;

  assign word_we   = byte_vld && !busy && st == DS_WLO && n_words < CW'(DEPTH);
  assign wide_addr = {hi_q, byte_i};
  assign rd_word   = stage_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (word_we) stage_mem[n_words[IW-1:0]] <= DW'({hi_q, byte_i});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= DS_CMD;
      hi_q        <= '0;
      staged      <= 1'b0;
      n_words     <= '0;
      start       <= 1'b0;
      start_addr  <= '0;
      stage_close <= 1'b0;
      err         <= 1'b0;
    end else begin
      start       <= 1'b0;
      stage_close <= 1'b0;
      if (seq_end) begin
        if ((st == DS_WHI || st == DS_WLO) && n_words != '0) begin
          staged      <= 1'b1;
          stage_close <= 1'b1;
        end
        st <= DS_CMD;
      end else if (byte_vld && !busy) begin
        case (st)
          DS_CMD: begin
            err <= 1'b0;
            if (byte_i == CMD_STAGE) begin
              n_words <= '0;
              staged  <= 1'b0;
              st      <= DS_WHI;
            end else if (byte_i == CMD_WRITE) begin
              st <= DS_AHI;
            end else begin
              st <= DS_SKIP;
            end
          end
          DS_WHI: begin
            hi_q <= byte_i;
            st   <= DS_WLO;
          end
          DS_WLO: begin
            if (word_we) n_words <= n_words + CW'(1);
            st <= DS_WHI;
          end
          DS_AHI: begin
            hi_q <= byte_i;
            st   <= DS_ALO;
          end
          DS_ALO: begin
            st     <= DS_SKIP;
            staged <= 1'b0;
            if (staged && (wide_addr >> AW) == 16'd0) begin
              start      <= 1'b1;
              start_addr <= wide_addr[AW-1:0];
            end else begin
              err <= 1'b1;
            end
          end
          default: st <= DS_SKIP;
        endcase
      end
    end
  end
endmodule

// File: rtl/coef_commit.sv
module coef_commit #(
  parameter int AW    = 10,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH),
  localparam int TW   = $clog2(2 * DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] n_words,
  input  logic [AW-1:0] exec_addr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [IW-1:0] idx,
  output logic          busy
);
  logic [AW-1:0] pend;
  logic [CW-1:0] remain;
  logic [TW-1:0] hold;

  assign we    = remain != '0 && exec_addr == pend;
  assign waddr = pend;
  assign busy  = remain != '0 || hold != '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      remain <= '0;
      hold   <= '0;
      idx    <= '0;
    end else if (start) begin
      pend   <= start_addr;
      remain <= n_words;
      idx    <= '0;
      hold   <= TW'(2 * (DEPTH - int'(n_words)));
    end else begin
      if (hold != '0) hold <= hold - TW'(1);
      if (we) begin
        pend   <= pend + AW'(1);
        idx    <= idx + IW'(1);
        remain <= remain - CW'(1);
      end
    end
  end
endmodule

// File: rtl/coef_ram.sv
module coef_ram #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= (we && waddr == raddr) ? wdata : mem[raddr];
  end
endmodule

// File: rtl/coef_defer_wr.sv
module coef_defer_wr #(
  parameter int DW    = 16,
  parameter int AW    = 10,
  parameter int DEPTH = 16,
  parameter int SYNC  = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_sclk,
  input  logic          host_sdi,
  input  logic [AW-1:0] exec_addr,
  output logic [DW-1:0] coef_rd,
  output logic          host_rdy,
  output logic          cmd_err
);
  logic          byte_vld, seq_end, busy, start, stage_close, we;
  logic [7:0]    byte_q;
  logic [IW-1:0] idx;
  logic [DW-1:0] wdata;
  logic [AW-1:0] start_addr, waddr;
  logic [CW-1:0] n_words;

  coef_ser_rx #(.SYNC(SYNC)) rx_i (
    .clk(clk), .rst(rst), .req_i(host_req), .sclk_i(host_sclk),
    .sdi_i(host_sdi), .byte_vld(byte_vld), .byte_q(byte_q), .seq_end(seq_end)
  );

  coef_cmd_dec #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) dec_i (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_i(byte_q),
    .seq_end(seq_end), .busy(busy), .rd_idx(idx), .rd_word(wdata),
    .start(start), .start_addr(start_addr), .n_words(n_words),
    .stage_close(stage_close), .err(cmd_err)
  );

  coef_commit #(.AW(AW), .DEPTH(DEPTH)) cmt_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .n_words(n_words), .exec_addr(exec_addr), .we(we), .waddr(waddr),
    .idx(idx), .busy(busy)
  );

  coef_ram #(.DW(DW), .AW(AW)) ram_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(exec_addr), .rdata(coef_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) host_rdy <= 1'b1;
    else     host_rdy <= ~(start | stage_close | busy);
  end
endmodule

// File: rtl/coef_defer_wr_chk.sv
module coef_defer_wr_chk #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          host_rdy,
  input logic          cmd_err,
  input logic [DW-1:0] coef_rd,
  input logic [AW-1:0] exec_addr,
  input logic          we,
  input logic [AW-1:0] waddr,
  input logic [DW-1:0] wdata,
  input logic          busy,
  input logic          start
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> host_rdy && !cmd_err); // R1
  AST_COMMIT_AT_EXEC: assert property (@(posedge clk) disable iff (rst)
    we |-> waddr == exec_addr); // R4
  AST_COMMIT_ORDER: assert property (@(posedge clk) disable iff (rst)
    we |=> waddr == AW'($past(waddr) + AW'(1))); // R5
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_err) |-> !busy && !we); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    busy |=> !host_rdy); // R8
  AST_READ_BYPASS: assert property (@(posedge clk) disable iff (rst)
    we |=> coef_rd == $past(wdata)); // R10
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start); // R11
endmodule

bind coef_defer_wr coef_defer_wr_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .host_rdy(host_rdy), .cmd_err(cmd_err),
  .coef_rd(coef_rd), .exec_addr(exec_addr), .we(we), .waddr(waddr),
  .wdata(wdata), .busy(busy), .start(start)
);

// File: tb/coef_defer_wr_tb_top.sv
`timescale 1ns/1ps
module coef_defer_wr_tb_top;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int IDLE_A = 500;
  localparam int NSTEP = 11;
  // R5: visit order {address, expected read}; early visits see old words
  localparam logic [25:0] STEPS [NSTEP] = '{
    {10'd11, 16'h1001}, {10'd10, 16'hB000}, {10'd12, 16'h1002},
    {10'd11, 16'hB001}, {10'd13, 16'h1003}, {10'd12, 16'hB002},
    {10'd13, 16'hB003}, {10'd16, 16'h1006}, {10'd14, 16'hB004},
    {10'd15, 16'h1005}, {10'd10, 16'hB000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic host_req = 1'b0, host_sclk = 1'b0, host_sdi = 1'b0;
  logic [AW-1:0] exec_addr = AW'(IDLE_A);
  logic [DW-1:0] coef_rd;
  logic host_rdy, cmd_err;
  int checks = 0, fails = 0, rdy_falls = 0;
  logic rdy_prev = 1'b1;

  always #10 clk = ~clk;

  coef_defer_wr dut_i (
    .clk(clk), .rst(rst), .host_req(host_req), .host_sclk(host_sclk),
    .host_sdi(host_sdi), .exec_addr(exec_addr), .coef_rd(coef_rd),
    .host_rdy(host_rdy), .cmd_err(cmd_err)
  );

  always @(negedge clk) begin
    if (rdy_prev && !host_rdy) rdy_falls++;
    rdy_prev <= host_rdy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) host_sdi = b[i];
      repeat (2) @(negedge clk);
      host_sclk = 1'b1;
      repeat (2) @(negedge clk);
      host_sclk = 1'b0;
    end
  endtask

  task automatic seq_open();
    @(negedge clk) host_req = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic seq_close();
    @(negedge clk) host_req = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    send_byte(w[15:8]);
    send_byte(w[7:0]);
  endtask

  task automatic write_cmd(input logic [7:0] hi, input logic [7:0] lo);
    seq_open();
    send_byte(8'hA4);
    send_byte(hi);
    send_byte(lo);
    seq_close();
  endtask

  task automatic read_at(input int a, input logic [15:0] exp, input string tag);
    @(negedge clk) exec_addr = AW'(a);
    @(negedge clk) chk(coef_rd == exp, tag, int'(coef_rd), int'(exp));
    exec_addr = AW'(IDLE_A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int falls0;
    repeat (3) @(negedge clk);
    chk(host_rdy == 1'b1, "R1 rdy in reset", int'(host_rdy), 1);
    chk(cmd_err == 1'b0, "R1 err in reset", int'(cmd_err), 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(host_rdy == 1'b1 && cmd_err == 1'b0, "R1 after reset", int'({host_rdy, cmd_err}), 2);

    // R2: 17 words staged, only 16 kept; targets 10..25
    seq_open();
    send_byte(8'hA8);
    for (int i = 0; i < 17; i++) send_word(16'h1000 + 16'(i));
    seq_close();
    write_cmd(8'h00, 8'h0A);
    chk(host_rdy == 1'b0, "R8 busy after write", int'(host_rdy), 0);
    for (int a = 10; a < 26; a++) read_at(a, 16'h1000 + 16'(a - 10), "R3 R4 R10 commit walk");
    repeat (4) @(negedge clk);
    chk(host_rdy == 1'b1, "R2 seventeenth word dropped", int'(host_rdy), 1);

    // R7: one-cycle ready drop on stage close
    falls0 = rdy_falls;
    seq_open();
    send_byte(8'hA8);
    for (int i = 0; i < 5; i++) send_word(16'hB000 + 16'(i));
    seq_close();
    chk(rdy_falls - falls0 == 1, "R7 ready pulse count", rdy_falls - falls0, 1);
    chk(host_rdy == 1'b1, "R7 ready back high", int'(host_rdy), 1);
    write_cmd(8'h00, 8'h0A);
    chk(host_rdy == 1'b0, "R8 busy after write n=5", int'(host_rdy), 0);
    // R11: staging sequence during commit is ignored
    seq_open();
    send_byte(8'hA8);
    send_word(16'h7777);
    seq_close();
    chk(host_rdy == 1'b0, "R8 still waiting for commits", int'(host_rdy), 0);
    for (int s = 0; s < NSTEP; s++)
      read_at(int'(STEPS[s][25:16]), STEPS[s][15:0], "R5 ordered visits");
    repeat (4) @(negedge clk);
    chk(host_rdy == 1'b1, "R8 ready after all commits", int'(host_rdy), 1);

    // R6 / R11: write without valid stage -> error, no write
    write_cmd(8'h00, 8'h0A);
    chk(cmd_err == 1'b1, "R11 R6 unprepared write flags", int'(cmd_err), 1);
    read_at(10, 16'hB000, "R6 R11 no write on error");
    chk(host_rdy == 1'b1, "R6 ready stays high", int'(host_rdy), 1);

    // R9: one full word plus a dangling byte; R8 minimum hold for n=1
    seq_open();
    send_byte(8'hA8);
    send_word(16'hC0DE);
    send_byte(8'h55);
    seq_close();
    write_cmd(8'h00, 8'h14);
    chk(cmd_err == 1'b0, "R6 error cleared by command", int'(cmd_err), 0);
    read_at(20, 16'hC0DE, "R3 R10 single word commit");
    chk(host_rdy == 1'b0, "R8 minimum hold n=1", int'(host_rdy), 0);
    repeat (40) @(negedge clk);
    chk(host_rdy == 1'b1, "R8 ready after hold", int'(host_rdy), 1);
    read_at(21, 16'h100B, "R9 partial word discarded");

    // R6: malformed address-high byte
    seq_open();
    send_byte(8'hA8);
    send_word(16'hDEAD);
    seq_close();
    write_cmd(8'h80, 8'h14);
    chk(cmd_err == 1'b1, "R6 bad high address byte", int'(cmd_err), 1);
    read_at(20, 16'hC0DE, "R6 bad address writes nothing");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule